// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit works out how many elements a vector operation may hold and grants vector lengths to software against that limit. Each configure command carries how many integer and floating-point registers one element uses, and how many register banks are active. From these the unit derives the maximum vector length. Each bank holds a fixed number of registers, and the elements share them. The result is capped at the number of hardware microthreads.

The division inside the derivation uses a small restoring divider that produces one quotient bit per cycle. While a configure is being worked out, both command channels hold their ready low. A set-length request waiting on its channel is accepted as soon as the new limit is in place. The request then grants the smaller of the requested length and the current maximum.

Both command channels are valid/ready. A command transfers on a rising clock edge where valid and ready are both high. The sender must keep valid and the payload steady until that edge. Ready does not depend on valid. `cfg_busy` and `cfg_done` are plain status pins.

Top module: `vlen_cfg_unit`

## Requirements
- R1: After reset `max_len` is min(32, MAX_THREADS), `vl` is 0, `cfg_busy` and `cfg_done` are 0, and both `cfg_ready` and `req_ready` are 1. The reset configuration is 32 integer registers, 32 floating-point registers and 8 banks.
- R2: A configure is accepted on an edge where `cfg_valid` and `cfg_ready` are both high. `cfg_busy` is then high for exactly $clog2(REG_PER_BANK+1)+1 cycles, which is 10 with the defaults. On the edge that ends the busy window, `max_len` takes its new value and `cfg_done` goes high for exactly one cycle.
- R3: When integer-used plus float-used is 2 or more, the new maximum is floor(REG_PER_BANK / (integer-used + float-used - 1)) times the bank count, before the cap in R5.
- R4: When integer-used plus float-used is 0 or 1, the new maximum is REG_PER_BANK times the bank count, before the cap in R5. This includes a bank count of 0.
- R5: The maximum length never exceeds MAX_THREADS. Any larger result is replaced by MAX_THREADS.
- R6: A set-length request is accepted on an edge where `req_valid` and `req_ready` are both high. From the next cycle, `vl` equals min(`max_len`, `req_len`), using the values seen at the accepting edge.
- R7: While `cfg_busy` is high, `cfg_ready` and `req_ready` are low. A `cfg_valid` pulse during that window is ignored and leaves `max_len` unchanged. A request held valid through the window is accepted in the `cfg_done` cycle and is clamped against the new maximum.
- R8: `max_len` changes only on the edge that raises `cfg_done`. `vl` changes only on an edge that accepts a request.
- R9: When a configure and a request are accepted on the same edge, the request is clamped against the maximum in force before that configure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configure command valid |
| cfg_ready | output | 1 | Configure command can be taken |
| cfg_int_used | input | USE_W | Integer registers used per element |
| cfg_fp_used | input | USE_W | Floating-point registers used per element |
| cfg_banks | input | BANK_W | Number of active banks |
| req_valid | input | 1 | Set-length request valid |
| req_ready | output | 1 | Set-length request can be taken |
| req_len | input | REQ_W | Requested vector length |
| cfg_busy | output | 1 | Maximum-length computation in progress |
| cfg_done | output | 1 | One-cycle pulse when a new maximum is in place |
| max_len | output | $clog2(MAX_THREADS+1) | Current maximum vector length |
| vl | output | $clog2(MAX_THREADS+1) | Granted vector length |

## Verification
The bench builds the unit with MAX_THREADS = 100 and keeps the defaults REG_PER_BANK = 256, USE_W = 6, BANK_W = 4 and REQ_W = 10. With these values the capped and uncapped outcomes both appear. A cap of 100 sits above the reset value of 32 and above several quotient-times-bank results such as 28 and 30, yet below 256 times any two or more banks. The 6-bit register counts allow sums up to 126, which drives the divisor close to its widest value. Requests up to 1023 exceed every limit, so clamping shows up on the granted length as well.

// File: rtl/vlcu_pkg.sv
package vlcu_pkg;
  // configuration held after reset
  localparam int RST_INT_USED = 32;
  localparam int RST_FP_USED  = 32;
  localparam int RST_BANKS    = 8;

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/vlcu_divider.sv
module vlcu_divider #(
  parameter int NW = 9,
  parameter int DW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic          busy,
  output logic          done,
  output logic [NW-1:0] quotient
);
  localparam int CW = $clog2(NW + 1);

  logic [DW-1:0] rem_q, dsr_q;
  logic [NW-1:0] qd_q;
  logic [CW-1:0] cnt_q;
  logic [DW:0]   trial;
  logic          fits;
  logic [DW-1:0] rem_n;

  always_comb begin
    trial = {rem_q, qd_q[NW-1]};
    fits  = trial >= {1'b0, dsr_q};
    rem_n = fits ? DW'(trial - {1'b0, dsr_q}) : trial[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
      dsr_q <= '0;
      qd_q  <= '0;
      cnt_q <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        rem_q <= rem_n;
        qd_q  <= {qd_q[NW-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (start) begin
        rem_q <= '0;
        qd_q  <= dividend;
        dsr_q <= divisor;
        cnt_q <= CW'(NW);
        busy  <= 1'b1;
      end
    end
  end

  assign quotient = qd_q;

  assert_rem_below_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rem_q < dsr_q));
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
endmodule

// File: rtl/vlcu_limit.sv
module vlcu_limit #(
  parameter int QW = 9,
  parameter int BW = 4,
  parameter int LW = 6,
  parameter int MAX_THREADS = 32
) (
  input  logic [QW-1:0] quotient,
  input  logic [BW-1:0] banks,
  output logic [LW-1:0] limit
);
  localparam int PW = QW + BW;
  logic [PW-1:0] prod;

  always_comb begin
    prod = PW'(quotient) * PW'(banks);
    if (prod > PW'(MAX_THREADS)) limit = LW'(MAX_THREADS);
    else                         limit = prod[LW-1:0];
  end
endmodule

// File: rtl/vlcu_grant.sv
module vlcu_grant #(
  parameter int LW = 6,
  parameter int RW = 10
) (
  input  logic [LW-1:0] max_len,
  input  logic [RW-1:0] req_len,
  output logic [LW-1:0] grant
);
  localparam int CW = (RW > LW) ? RW : LW;
  logic [CW-1:0] m_ext, r_ext;

  always_comb begin
    m_ext = CW'(max_len);
    r_ext = CW'(req_len);
    grant = (r_ext < m_ext) ? LW'(r_ext) : max_len;
  end
endmodule

// File: rtl/vlen_cfg_unit.sv
module vlen_cfg_unit #(
  parameter int REG_PER_BANK = 256,
  parameter int MAX_THREADS  = 32,
  parameter int USE_W        = 6,
  parameter int BANK_W       = 4,
  parameter int REQ_W        = 10,
  localparam int LW = $clog2(MAX_THREADS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic [USE_W-1:0]  cfg_int_used,
  input  logic [USE_W-1:0]  cfg_fp_used,
  input  logic [BANK_W-1:0] cfg_banks,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [REQ_W-1:0]  req_len,
  output logic              cfg_busy,
  output logic              cfg_done,
  output logic [LW-1:0]     max_len,
  output logic [LW-1:0]     vl
);
  import vlcu_pkg::*;

  localparam int QW = $clog2(REG_PER_BANK + 1);
  localparam int DW = USE_W + 1;
  localparam int RST_MAX = imin((REG_PER_BANK / (RST_INT_USED + RST_FP_USED - 1)) * RST_BANKS,
                                MAX_THREADS);

  logic [DW-1:0]     use_sum, divisor;
  logic [BANK_W-1:0] banks_q;
  logic              div_busy, div_done, cfg_fire, req_fire;
  logic [QW-1:0]     quotient;
  logic [LW-1:0]     lim_val, grant_val, max_len_q, vl_q;
  logic              cfg_done_q;

  assign cfg_busy  = div_busy | div_done;
  assign cfg_ready = !cfg_busy;
  assign req_ready = !cfg_busy;
  assign cfg_fire  = cfg_valid && cfg_ready;
  assign req_fire  = req_valid && req_ready;

  always_comb begin
    use_sum = DW'(cfg_int_used) + DW'(cfg_fp_used);
    divisor = (use_sum < DW'(2)) ? DW'(1) : use_sum - DW'(1);
  end

  vlcu_divider #(.NW(QW), .DW(DW)) u_div (
    .clk(clk), .rst_n(rst_n), .start(cfg_fire),
    .dividend(QW'(REG_PER_BANK)), .divisor(divisor),
    .busy(div_busy), .done(div_done), .quotient(quotient)
  );

  vlcu_limit #(.QW(QW), .BW(BANK_W), .LW(LW), .MAX_THREADS(MAX_THREADS)) u_lim (
    .quotient(quotient), .banks(banks_q), .limit(lim_val)
  );

  vlcu_grant #(.LW(LW), .RW(REQ_W)) u_grant (
    .max_len(max_len_q), .req_len(req_len), .grant(grant_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      banks_q    <= BANK_W'(RST_BANKS);
      max_len_q  <= LW'(RST_MAX);
      vl_q       <= '0;
      cfg_done_q <= 1'b0;
    end else begin
      cfg_done_q <= div_done;
      if (cfg_fire) banks_q <= cfg_banks;
      if (div_done) max_len_q <= lim_val;
      if (req_fire) vl_q <= grant_val;
    end
  end

  assign max_len  = max_len_q;
  assign vl       = vl_q;
  assign cfg_done = cfg_done_q;

  assert_max_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    max_len_q <= LW'(MAX_THREADS));
  assert_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> (vl_q == (($past(req_len) < REQ_W'($past(max_len_q))) ?
                           LW'($past(req_len)) : $past(max_len_q))));
  assert_max_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(max_len_q) |-> cfg_done_q);
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_done_q |=> !cfg_done_q);
  assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |-> (!req_fire && !cfg_fire));
endmodule

// File: tb/vlen_cfg_unit_bench.sv
module vlen_cfg_unit_bench;
  localparam int PERIOD = 10;
  localparam int MT     = 100;
  localparam int RPB    = 256;
  localparam int LW     = $clog2(MT + 1);
  localparam int BUSY_CYC = 10;   // R2: $clog2(257)+1

  logic clk = 0, rst_n = 0;
  logic cfg_valid = 0, req_valid = 0;
  logic [5:0] cfg_int_used = 0, cfg_fp_used = 0;
  logic [3:0] cfg_banks = 0;
  logic [9:0] req_len = 0;
  logic cfg_ready, req_ready, cfg_busy, cfg_done;
  logic [LW-1:0] max_len, vl;

  int vectors = 0, fails = 0;
  string cur_req = "R1";
  bit finished = 0;

  vlen_cfg_unit #(.MAX_THREADS(MT)) u_vlen_cfg_unit (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_int_used(cfg_int_used), .cfg_fp_used(cfg_fp_used), .cfg_banks(cfg_banks),
    .req_valid(req_valid), .req_ready(req_ready), .req_len(req_len),
    .cfg_busy(cfg_busy), .cfg_done(cfg_done), .max_len(max_len), .vl(vl)
  );

  always #(PERIOD/2) clk = ~clk;

  // behavioural reference
  int m_cnt, m_max, m_vl, m_pend;
  bit m_done;

  function automatic int calc_max(int iu, int fu, int b);
    int s, q;
    s = iu + fu;
    if (s < 2) q = RPB * b;            // R4
    else       q = (RPB / (s - 1)) * b; // R3
    return (q > MT) ? MT : q;          // R5
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_max = (32 < MT) ? 32 : MT; m_vl = 0; m_done = 0; m_pend = 0;
    end else begin
      int old_max;
      bit idle;
      old_max = m_max;
      idle = (m_cnt == 0);
      m_done = 0;
      if (!idle) begin
        if (m_cnt == 1) begin m_max = m_pend; m_done = 1; end
        m_cnt = m_cnt - 1;
      end else if (cfg_valid) begin
        m_cnt  = BUSY_CYC;
        m_pend = calc_max(cfg_int_used, cfg_fp_used, cfg_banks);
      end
      if (req_valid && idle)
        m_vl = (int'(req_len) < old_max) ? int'(req_len) : old_max; // R6, R9
    end
  end

  task automatic cmp(string what, int act, int exp);
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      vectors++;
      cmp("cfg_ready", cfg_ready, m_cnt == 0);
      cmp("req_ready", req_ready, m_cnt == 0);
      cmp("cfg_busy",  cfg_busy,  m_cnt != 0);
      cmp("cfg_done",  cfg_done,  m_done);
      cmp("max_len",   max_len,   m_max);
      cmp("vl",        vl,        m_vl);
    end
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic do_cfg(int iu, int fu, int b);
    bit r;
    cfg_int_used = 6'(iu); cfg_fp_used = 6'(fu); cfg_banks = 4'(b);
    cfg_valid = 1;
    do begin @(negedge clk); r = cfg_ready; @(posedge clk); #1; end while (!r);
    cfg_valid = 0;
  endtask

  task automatic do_req(int len);
    bit r;
    req_len = 10'(len); req_valid = 1;
    do begin @(negedge clk); r = req_ready; @(posedge clk); #1; end while (!r);
    req_valid = 0;
  endtask

  task automatic wait_idle();
    while (cfg_busy) step(1);
    step(2);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1;
    cur_req = "R1"; step(3);
    cur_req = "R6"; do_req(50); step(2); do_req(7); step(2); do_req(1023); step(2);
    cur_req = "R3"; do_cfg(5, 5, 1); wait_idle();          // 28
    cur_req = "R7"; do_cfg(32, 32, 8); step(2); do_req(100); step(2); // stalled, 32
    cur_req = "R7"; do_cfg(5, 5, 1); step(3);
    cfg_int_used = 0; cfg_fp_used = 0; cfg_banks = 15; cfg_valid = 1; step(1); cfg_valid = 0;
    wait_idle(); do_req(1023); step(2);                    // 28 stays
    cur_req = "R4"; do_cfg(1, 0, 2); wait_idle();          // 512 -> 100
    cur_req = "R5"; do_req(1023); step(2);
    cur_req = "R4"; do_cfg(0, 0, 0); wait_idle(); do_req(9); step(2);
    cur_req = "R3"; do_cfg(2, 0, 3); wait_idle();          // boundary sum 2
    cur_req = "R3"; do_cfg(63, 63, 15); wait_idle(); do_req(1000); step(2); // 30
    cur_req = "R9";
    cfg_int_used = 4; cfg_fp_used = 4; cfg_banks = 1;
    req_len = 500; cfg_valid = 1; req_valid = 1; step(1);
    cfg_valid = 0; req_valid = 0; wait_idle();             // vl 30, max 36
    cur_req = "R8"; step(5); do_req(20); step(3);
    cur_req = "R2"; do_cfg(3, 4, 7); step(BUSY_CYC + 3);
    finish_run();
  end
endmodule